// File: doc/BRIEF.md
# DRAM Bank State Command Tracker

This block watches the command bus of a double-data-rate DRAM from the controller or checker side. Each clock it decodes the chip-select, row-strobe, column-strobe and write-enable pins into activate, read, write or precharge. It keeps, for every bank, whether a row is open and which row it is. Each recognised command produces one registered decode record one clock later. The record gives the bank, the row (taken from the address for an activate, from the tracked state for a column command), the column, the auto-precharge request and whether the burst is chopped to four words.

Command orders that break the bank protocol raise an error flag in the same record and leave the tracked state untouched. Such orders are an activate to a bank that is already open, and a read or write to a bank that is not ready. A read or write that asks for auto-precharge closes its bank by itself once the burst's data clocks have passed. Two data words cross per clock, so a full burst takes `BL8_CLKS` clocks and a chopped burst takes half that. The burst length comes from address bit 12 when on-the-fly selection is enabled. Otherwise it comes from a fixed configuration input.

Top module: `dram_bank_tracker`

## Requirements
- R1: Pins (cs_n, ras_n, cas_n, we_n) decode as 0011 activate, 0101 read, 0100 write, 0010 precharge. One clock after such a command, `dec_valid` is 1 and `dec_cmd` reads 1, 2, 3 or 4 respectively. Chip-select high, no-operation (0111) and every other encoding give `dec_valid` 0 and change no bank state.
- R2: A legal activate opens the bank named by `cmd_ba` and stores `cmd_addr` as its row. The next clock shows the bank's bit set in `bank_open` and the address on `dec_row`.
- R3: A read or write reports the stored row of its bank on `dec_row` and `cmd_addr[COL_W-1:0]` on `dec_col`.
- R4: A precharge with address bit 10 low closes only the addressed bank. With bit 10 high it closes every bank and sets `dec_pre_all`. A precharge never raises `seq_err`.
- R5: With `cfg_otf_en` high, a read or write with address bit 12 low reports `dec_chop` 1 (four words), and with bit 12 high it reports `dec_chop` 0 (eight words).
- R6: With `cfg_otf_en` low, `dec_chop` equals `cfg_fixed_bc4` and address bit 12 has no effect.
- R7: A legal read or write with address bit 10 high reports `dec_autopre` 1. Its bank's `bank_open` bit falls at the clock edge `BL8_CLKS` edges after the command edge (4 by default), or `BL8_CLKS/2` edges after it when chopped.
- R8: An activate to an open bank sets `seq_err`, and the bank keeps its previous row.
- R9: A read or write to a closed bank, or to a bank whose auto-precharge is still counting, sets `seq_err` and schedules no auto-precharge.
- R10: An activate presented at the very edge where an auto-precharge closes that bank is legal. The bank reopens with the new row.
- R11: During reset all banks are closed and every decode output is 0.
- R12: A precharge to a bank with a pending auto-precharge closes it at once and cancels the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_ba | input | BANK_W | Bank address |
| cmd_addr | input | ADDR_W | Row, column and option address |
| cfg_otf_en | input | 1 | Burst length taken from address bit 12 per command |
| cfg_fixed_bc4 | input | 1 | Fixed burst choice when on-the-fly is off: 1 chopped, 0 full |
| dec_valid | output | 1 | Decode record valid |
| dec_cmd | output | 3 | 1 activate, 2 read, 3 write, 4 precharge |
| dec_bank | output | BANK_W | Bank of the command |
| dec_row | output | ADDR_W | Opened or tracked row |
| dec_col | output | COL_W | Starting column |
| dec_autopre | output | 1 | Auto-precharge requested on a column command |
| dec_pre_all | output | 1 | Precharge addressed every bank |
| dec_chop | output | 1 | Burst chopped to four words |
| seq_err | output | 1 | Command violated bank order |
| bank_open | output | NBANK | Open status per bank |

## Verification
The interesting overlap is the auto-precharge countdown expiring on the same edge as a new command to that bank. The bench issues a read with auto-precharge and waits exactly three clocks. It then presents an activate to the same bank, so both land on the closing edge. The activate must be accepted without error, and a later read must report the new row. A second collision puts a precharge on a bank whose countdown is still running. The bank must close at once and stay closed after the original expiry point.

// File: rtl/dbt_pkg.sv
`timescale 1ns/1ps
// Shared types for the bank tracker.
// Assumes the four control pins are sampled together on the rising clock.
package dbt_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4
    } cmd_e;

endpackage

// File: rtl/dbt_cmd_decode.sv
`timescale 1ns/1ps
// Combinational command decoder.
// Maps the control pins to a command kind and resolves the column options:
// auto-precharge, precharge-all and burst chop.
// Assumes the pins are already synchronous to clk; performs no checking.
module dbt_cmd_decode
    import dbt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic a12,
    input  logic otf_en,
    input  logic fixed_bc4,
    output cmd_e kind,
    output logic is_col,
    output logic ap_req,
    output logic pre_all,
    output logic chop
);

    // Pin pattern to command kind; deselect and unknown patterns give none
    always_comb begin
        kind = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  kind = CMD_ACT;
                3'b101:  kind = CMD_RD;
                3'b100:  kind = CMD_WR;
                3'b010:  kind = CMD_PRE;
                default: kind = CMD_NONE;
            endcase
        end
    end

    // Option bits only carry meaning for the command kinds that use them
    always_comb begin
        is_col  = (kind == CMD_RD) || (kind == CMD_WR);
        ap_req  = is_col && a10;
        pre_all = (kind == CMD_PRE) && a10;
        chop    = 1'b0;
        if (is_col) begin
            chop = otf_en ? ~a12 : fixed_bc4;
        end
    end

endmodule

// File: rtl/dbt_bank_slot.sv
`timescale 1ns/1ps
// State of one bank: open flag, stored row and auto-precharge countdown.
// Assumes the controls arrive already qualified: at most one of act_i and
// ap_i per cycle, and pre_i takes priority over both.
module dbt_bank_slot #(
    parameter int ROW_W = 16,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             ap_i,
    input  logic [CNT_W-1:0] ap_len_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             pend_o,
    output logic             closing_o
);

    logic [CNT_W-1:0] cnt_q;

    // Open/close and countdown update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            pend_o <= 1'b0;
            cnt_q  <= '0;
            row_o  <= '0;
        end else if (pre_i) begin
            open_o <= 1'b0;
            pend_o <= 1'b0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
            pend_o <= 1'b0;
        end else if (ap_i) begin
            pend_o <= 1'b1;
            cnt_q  <= ap_len_i;
        end else if (pend_o) begin
            if (cnt_q == '0) begin
                open_o <= 1'b0;
                pend_o <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // The bank closes at the coming edge unless something overrides it
    assign closing_o = pend_o && (cnt_q == '0);

endmodule

// File: rtl/dram_bank_tracker.sv
`timescale 1ns/1ps
// Bank state command tracker for a DDR-style command bus.
// Decodes each command, checks it against per-bank state, updates that
// state, and emits one registered decode record per recognised command.
// Assumes NBANK is a power of two and COL_W does not exceed 10.
module dram_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NBANK    = 8,
    parameter int ADDR_W   = 16,
    parameter int COL_W    = 10,
    parameter int BL8_CLKS = 4,
    parameter int BANK_W   = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_cs_n,
    input  logic              cmd_ras_n,
    input  logic              cmd_cas_n,
    input  logic              cmd_we_n,
    input  logic [BANK_W-1:0] cmd_ba,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cfg_otf_en,
    input  logic              cfg_fixed_bc4,
    output logic              dec_valid,
    output logic [2:0]        dec_cmd,
    output logic [BANK_W-1:0] dec_bank,
    output logic [ADDR_W-1:0] dec_row,
    output logic [COL_W-1:0]  dec_col,
    output logic              dec_autopre,
    output logic              dec_pre_all,
    output logic              dec_chop,
    output logic              seq_err,
    output logic [NBANK-1:0]  bank_open
);

    localparam int BC4_CLKS = BL8_CLKS / 2;
    localparam int CNT_W    = $clog2(BL8_CLKS + 1);
    localparam int AP_BIT   = 10;
    localparam int BC_BIT   = 12;

    cmd_e             kind;
    logic             is_col, ap_req, pre_all, chop;
    logic [NBANK-1:0] pend, closing, sel;
    logic [ADDR_W-1:0] bank_row [NBANK];
    logic             err;
    logic [CNT_W-1:0] ap_len;

    dbt_cmd_decode i_dec (
        .cs_n      (cmd_cs_n),
        .ras_n     (cmd_ras_n),
        .cas_n     (cmd_cas_n),
        .we_n      (cmd_we_n),
        .a10       (cmd_addr[AP_BIT]),
        .a12       (cmd_addr[BC_BIT]),
        .otf_en    (cfg_otf_en),
        .fixed_bc4 (cfg_fixed_bc4),
        .kind      (kind),
        .is_col    (is_col),
        .ap_req    (ap_req),
        .pre_all   (pre_all),
        .chop      (chop)
    );

    // One-hot select of the addressed bank
    always_comb begin
        sel = '0;
        sel[cmd_ba] = 1'b1;
    end

    // Order check: activate needs a bank that is closed or closing now,
    // column commands need an open bank with no countdown running
    always_comb begin
        err = 1'b0;
        if (kind == CMD_ACT) begin
            err = bank_open[cmd_ba] && !closing[cmd_ba];
        end else if (is_col) begin
            err = !(bank_open[cmd_ba] && !pend[cmd_ba]);
        end
    end

    // Countdown reload value from the resolved burst length
    assign ap_len = chop ? CNT_W'(BC4_CLKS - 1) : CNT_W'(BL8_CLKS - 1);

    // One state slot per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dbt_bank_slot #(
            .ROW_W (ADDR_W),
            .CNT_W (CNT_W)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     ((kind == CMD_ACT) && sel[b] && !err),
            .pre_i     ((kind == CMD_PRE) && (pre_all || sel[b])),
            .ap_i      (ap_req && sel[b] && !err),
            .ap_len_i  (ap_len),
            .row_i     (cmd_addr),
            .open_o    (bank_open[b]),
            .row_o     (bank_row[b]),
            .pend_o    (pend[b]),
            .closing_o (closing[b])
        );
    end

    // Registered decode record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_cmd     <= CMD_NONE;
            dec_bank    <= '0;
            dec_row     <= '0;
            dec_col     <= '0;
            dec_autopre <= 1'b0;
            dec_pre_all <= 1'b0;
            dec_chop    <= 1'b0;
            seq_err     <= 1'b0;
        end else begin
            dec_valid   <= (kind != CMD_NONE);
            dec_cmd     <= kind;
            dec_bank    <= cmd_ba;
            dec_row     <= (kind == CMD_ACT) ? cmd_addr
                         : (is_col ? bank_row[cmd_ba] : '0);
            dec_col     <= is_col ? cmd_addr[COL_W-1:0] : '0;
            dec_autopre <= ap_req;
            dec_pre_all <= pre_all;
            dec_chop    <= chop;
            seq_err     <= err;
        end
    end

endmodule

// Protocol checker bound to the tracker.
// Relates the decode record to bank state before and after each command.
module dbt_checker #(
    parameter int NBANK  = 8,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_cs_n,
    input logic              cfg_otf_en,
    input logic              cfg_fixed_bc4,
    input logic              dec_valid,
    input logic [2:0]        dec_cmd,
    input logic [BANK_W-1:0] dec_bank,
    input logic              dec_autopre,
    input logic              dec_pre_all,
    input logic              dec_chop,
    input logic              seq_err,
    input logic [NBANK-1:0]  bank_open
);

    logic [NBANK-1:0] open_d;

    // Bank status as it stood before the latest edge
    always_ff @(posedge clk) begin
        if (!rst_n) open_d <= '0;
        else        open_d <= bank_open;
    end

    // R11
    reset_closed_chk: assert property (@(posedge clk)
        !rst_n |=> (bank_open == '0 && !dec_valid));

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_cs_n) |-> !dec_valid);

    // R1
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_cmd >= 3'd1 && dec_cmd <= 3'd4));

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cmd == 3'd1 && !seq_err) |-> bank_open[dec_bank]);

    // R9
    col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_cmd == 3'd2 || dec_cmd == 3'd3) && !seq_err)
        |-> open_d[dec_bank]);

    // R4
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cmd == 3'd4 && dec_pre_all) |-> (bank_open == '0 && !seq_err));

    // R6
    fixed_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_cmd == 3'd2 || dec_cmd == 3'd3) && !$past(cfg_otf_en))
        |-> (dec_chop == $past(cfg_fixed_bc4)));

    // R7
    autopre_col_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_autopre |-> (dec_valid && (dec_cmd == 3'd2 || dec_cmd == 3'd3)));

endmodule

bind dram_bank_tracker dbt_checker #(
    .NBANK  (NBANK),
    .BANK_W (BANK_W)
) i_dbt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_cs_n      (cmd_cs_n),
    .cfg_otf_en    (cfg_otf_en),
    .cfg_fixed_bc4 (cfg_fixed_bc4),
    .dec_valid     (dec_valid),
    .dec_cmd       (dec_cmd),
    .dec_bank      (dec_bank),
    .dec_autopre   (dec_autopre),
    .dec_pre_all   (dec_pre_all),
    .dec_chop      (dec_chop),
    .seq_err       (seq_err),
    .bank_open     (bank_open)
);

// File: tb/test_dram_bank_tracker.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_dram_bank_tracker;

    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_DES = 4'b1011;
    localparam logic [15:0] A10 = 16'h0400;
    localparam logic [15:0] A12 = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic        otf = 1'b1, fbc4 = 1'b0;
    logic        dec_valid, dec_autopre, dec_pre_all, dec_chop, seq_err;
    logic [2:0]  dec_cmd, dec_bank;
    logic [15:0] dec_row;
    logic [9:0]  dec_col;
    logic [7:0]  bank_open;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dram_bank_tracker i_dram_bank_tracker (
        .clk(clk), .rst_n(rst_n),
        .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
        .cmd_ba(ba), .cmd_addr(addr),
        .cfg_otf_en(otf), .cfg_fixed_bc4(fbc4),
        .dec_valid(dec_valid), .dec_cmd(dec_cmd), .dec_bank(dec_bank),
        .dec_row(dec_row), .dec_col(dec_col), .dec_autopre(dec_autopre),
        .dec_pre_all(dec_pre_all), .dec_chop(dec_chop), .seq_err(seq_err),
        .bank_open(bank_open)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command for one edge, starting at a falling edge; returns at
    // the next falling edge, when the decode record is visible
    task automatic send(input logic [3:0] p, input logic [2:0] b, input logic [15:0] a);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 bank_open", bank_open, 8'h00);
        chk("R11 dec_valid", dec_valid, 0);
        chk("R11 seq_err", seq_err, 0);
    endtask

    task automatic t_act;
        send(P_ACT, 3'd2, 16'h1234);
        chk("R1 valid", dec_valid, 1);
        chk("R1 act code", dec_cmd, 3'd1);
        chk("R2 row", dec_row, 16'h1234);
        chk("R2 bank", dec_bank, 3'd2);
        chk("R2 open", bank_open, 8'h04);
    endtask

    task automatic t_col_otf;
        otf = 1'b1;
        send(P_RD, 3'd2, A12 | 16'h005A);
        chk("R1 rd code", dec_cmd, 3'd2);
        chk("R3 rd row", dec_row, 16'h1234);
        chk("R3 rd col", dec_col, 10'h05A);
        chk("R5 a12 high full", dec_chop, 0);
        chk("R7 no autopre", dec_autopre, 0);
        send(P_WR, 3'd2, 16'h0123);
        chk("R1 wr code", dec_cmd, 3'd3);
        chk("R5 a12 low chop", dec_chop, 1);
        chk("R3 wr col", dec_col, 10'h123);
    endtask

    task automatic t_fixed;
        otf = 1'b0;
        fbc4 = 1'b1;
        send(P_RD, 3'd2, A12);
        chk("R6 fixed chop ignores a12", dec_chop, 1);
        fbc4 = 1'b0;
        send(P_WR, 3'd2, 16'h0000);
        chk("R6 fixed full ignores a12", dec_chop, 0);
        otf = 1'b1;
    endtask

    task automatic t_ignored;
        send(P_NOP, 3'd2, 16'h0);
        chk("R1 nop", dec_valid, 0);
        send(P_DES, 3'd3, 16'h7777);
        chk("R1 deselect", dec_valid, 0);
        send(P_REF, 3'd4, 16'h0);
        chk("R1 other code", dec_valid, 0);
        chk("R1 state kept", bank_open, 8'h04);
    endtask

    task automatic t_errors;
        send(P_ACT, 3'd2, 16'h0BAD);
        chk("R8 act open err", seq_err, 1);
        send(P_RD, 3'd2, 16'h0);
        chk("R8 row kept", dec_row, 16'h1234);
        chk("R8 no err after", seq_err, 0);
        send(P_RD, 3'd5, 16'h0);
        chk("R9 rd closed err", seq_err, 1);
        send(P_WR, 3'd5, A10);
        chk("R9 wr closed err", seq_err, 1);
        idle(5);
        chk("R9 no state change", bank_open, 8'h04);
    endtask

    task automatic t_pre;
        send(P_ACT, 3'd5, 16'h0055);
        send(P_PRE, 3'd2, 16'h0);
        chk("R4 single", bank_open, 8'h20);
        chk("R4 no all", dec_pre_all, 0);
        chk("R1 pre code", dec_cmd, 3'd4);
        send(P_ACT, 3'd2, 16'h0022);
        send(P_PRE, 3'd0, A10);
        chk("R4 all closed", bank_open, 8'h00);
        chk("R4 all flag", dec_pre_all, 1);
        chk("R4 no err", seq_err, 0);
    endtask

    task automatic t_ap_bl8;
        send(P_ACT, 3'd1, 16'h0111);
        send(P_RD, 3'd1, A10 | A12);
        chk("R7 autopre flag", dec_autopre, 1);
        send(P_RD, 3'd1, 16'h0);
        chk("R9 rd during countdown err", seq_err, 1);
        idle(2);
        chk("R7 bl8 open at 3", bank_open[1], 1);
        idle(1);
        chk("R7 bl8 closed at 4", bank_open[1], 0);
    endtask

    task automatic t_ap_bc4;
        send(P_ACT, 3'd3, 16'h0333);
        send(P_WR, 3'd3, A10);
        chk("R7 bc4 chop", dec_chop, 1);
        idle(1);
        chk("R7 bc4 open at 1", bank_open[3], 1);
        idle(1);
        chk("R7 bc4 closed at 2", bank_open[3], 0);
    endtask

    task automatic t_same_edge;
        send(P_ACT, 3'd4, 16'h0AAA);
        send(P_RD, 3'd4, A10 | A12);
        idle(3);
        send(P_ACT, 3'd4, 16'h0BBB);
        chk("R10 act at close edge legal", seq_err, 0);
        chk("R10 reopened", bank_open[4], 1);
        send(P_RD, 3'd4, 16'h0);
        chk("R10 new row", dec_row, 16'h0BBB);
        chk("R10 rd legal", seq_err, 0);
        send(P_PRE, 3'd4, 16'h0);
    endtask

    task automatic t_pre_pending;
        send(P_ACT, 3'd6, 16'h0666);
        send(P_WR, 3'd6, A10 | A12);
        send(P_PRE, 3'd6, 16'h0);
        chk("R12 closed now", bank_open[6], 0);
        idle(5);
        chk("R12 stays closed", bank_open[6], 0);
        send(P_ACT, 3'd6, 16'h0667);
        chk("R12 reopen legal", seq_err, 0);
        chk("R12 open", bank_open[6], 1);
    endtask

    initial begin
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(1);
        t_act;
        t_col_otf;
        t_fixed;
        t_ignored;
        t_errors;
        t_pre;
        t_ap_bl8;
        t_ap_bc4;
        t_same_edge;
        t_pre_pending;
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule